// File: doc/BRIEF.md
# Clock Phase Step Request Sequencer

This block sits between user logic and the dynamic phase-adjust port of a clock manager. User logic hands it a signed step count through a valid/ready handshake. The block then drives that many single-step commands into the clock manager, one at a time. Each command is a one-cycle enable pulse together with a direction bit. After each command the block waits for the manager's one-cycle completion pulse before it sends the next one. The time until completion varies, so the block never uses a timeout to stand in for that pulse.

Each step moves the output clock phase by 1/256 of the input clock period. The block keeps a signed estimate of the current phase offset. In variable mode the offset starts at a configured initial phase and is held within -255 to +255. In direct mode it starts at 0 and is held within 0 to 1023.

The manager can flag a completed step with its overflow status. In that case the phase did not move, so the estimate is left alone. The rest of the request is dropped and a sticky error is raised. Deasserting the lock input returns the block to idle at once. Everything runs in the phase-adjust clock domain.

Top module: `phase_step_seq`

## Requirements
- R1: A synchronous reset leaves the block idle: busy low, done low, enable low and error low. Ready is high when lock is high. The position holds INIT_PHASE in variable mode (DIRECT_MODE=0) and 0 in direct mode (DIRECT_MODE=1).
- R2: Every enable pulse lasts exactly one cycle. The direction output is 1 for a positive request count (increment) and 0 for a negative one (decrement), and it holds that value during the pulse.
- R3: After an enable pulse, no further enable is issued until the completion input has been seen high. A request of count N with no overflow produces exactly |N| enable pulses.
- R4: Each completion without overflow moves the position by +1 for an increment or -1 for a decrement, one cycle after the completion is sampled. The position never leaves -255..+255 in variable mode or 0..1023 in direct mode.
- R5: When the overflow input is high together with the completion input, the position is left unchanged. The remaining steps of the request are dropped, and the error output goes high and stays high.
- R6: The error output is cleared when the next request is accepted, including a request of zero steps.
- R7: A request of zero steps gives a done pulse in the cycle after acceptance, with no enable pulse.
- R8: Ready is low while a request is in progress or while lock is low. A valid request presented while ready is low is ignored.
- R9: When lock is low at a clock edge, the block is idle after that edge and issues no enable while lock stays low. The position is left unchanged.
- R10: Done pulses high for exactly one cycle, in the cycle after the final completion (or the overflow completion) is sampled, and the block is idle in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase-adjust clock |
| rst | input | 1 | Synchronous reset, active high |
| locked_i | input | 1 | Clock manager locked |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request can be accepted |
| req_steps_i | input | STEP_W | Signed step count of the request |
| ps_en_o | output | 1 | One-cycle step command to the clock manager |
| ps_incdec_o | output | 1 | Step direction, 1 = increment |
| ps_done_i | input | 1 | One-cycle step completion from the clock manager |
| ps_ovf_i | input | 1 | Overflow status from the clock manager, read with completion |
| busy_o | output | 1 | A request is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a request |
| ovf_err_o | output | 1 | Sticky overflow error of the last request |
| phase_pos_o | output | POS_W | Signed tracked phase offset in steps |

## Verification
Each result has a fixed delay. The first enable appears one cycle after the request is accepted. Both the new position and the next enable (or the done pulse) appear one cycle after a completion is sampled. A zero-step request gives its done pulse one cycle after acceptance, and the block is idle one cycle after lock is seen low.

The bench drives inputs and samples outputs on falling clock edges, so each check reads the value that exactly one register stage has produced. It also holds its completion pulse back for a random number of cycles, and checks in each waiting cycle that no enable appears. A small model of the clock manager counter decides when overflow is reported.

// File: rtl/psq_pkg.sv
package psq_pkg;

  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_ISSUE  = 2'd1,
    S_WAIT   = 2'd2,
    S_FINISH = 2'd3
  } psq_state_e;

  // Lower bound of the tracked position for the chosen mode.
  function automatic int pos_floor(input bit direct_mode);
    return direct_mode ? 0 : -255;
  endfunction

  // Upper bound of the tracked position for the chosen mode.
  function automatic int pos_ceiling(input bit direct_mode);
    return direct_mode ? 1023 : 255;
  endfunction

endpackage

// File: rtl/psq_req_decode.sv
module psq_req_decode #(
  parameter int STEP_W = 11
) (
  input  logic signed [STEP_W-1:0] steps_i,
  output logic        [STEP_W-1:0] mag_o,
  output logic                     up_o,
  output logic                     zero_o
);

  // Magnitude of a signed count; the most negative value maps to 2^(STEP_W-1).
  function automatic logic [STEP_W-1:0] magnitude(input logic signed [STEP_W-1:0] s);
    logic [STEP_W-1:0] neg;
    neg = ~s + 1'b1;
    return s[STEP_W-1] ? neg : s;
  endfunction

  always_comb begin
    mag_o  = magnitude(steps_i);
    up_o   = ~steps_i[STEP_W-1];
    zero_o = (steps_i == '0);
  end

endmodule

// File: rtl/psq_ctrl.sv
module psq_ctrl
  import psq_pkg::*;
#(
  parameter int STEP_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              locked_i,
  input  logic              req_valid_i,
  input  logic [STEP_W-1:0] req_mag_i,
  input  logic              req_up_i,
  input  logic              req_zero_i,
  input  logic              ps_done_i,
  input  logic              ps_ovf_i,
  output logic              req_ready_o,
  output logic              accept_o,
  output logic              ps_en_o,
  output logic              ps_dir_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              step_ok_o,
  output logic              step_ovf_o
);

  psq_state_e        state_q;
  logic [STEP_W-1:0] rem_q;
  logic              up_q;
  logic              err_q;
  logic              completion;
  logic              last_step;

  always_comb begin
    req_ready_o = (state_q == S_IDLE) && locked_i;
    accept_o    = req_ready_o && req_valid_i;
    completion  = (state_q == S_WAIT) && ps_done_i && locked_i;
    step_ok_o   = completion && !ps_ovf_i;
    step_ovf_o  = completion && ps_ovf_i;
    last_step   = (rem_q == STEP_W'(1));
    ps_en_o     = (state_q == S_ISSUE);
    ps_dir_o    = up_q;
    busy_o      = (state_q != S_IDLE);
    done_o      = (state_q == S_FINISH);
    err_o       = err_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      rem_q   <= '0;
      up_q    <= 1'b0;
      err_q   <= 1'b0;
    end else if (!locked_i) begin
      state_q <= S_IDLE;
    end else begin
      case (state_q)
        S_IDLE: begin
          if (accept_o) begin
            err_q   <= 1'b0;
            rem_q   <= req_mag_i;
            up_q    <= req_up_i;
            state_q <= req_zero_i ? S_FINISH : S_ISSUE;
          end
        end
        S_ISSUE: state_q <= S_WAIT;
        S_WAIT: begin
          if (step_ovf_o) begin
            err_q   <= 1'b1;
            state_q <= S_FINISH;
          end else if (step_ok_o) begin
            rem_q   <= rem_q - 1'b1;
            state_q <= last_step ? S_FINISH : S_ISSUE;
          end
        end
        S_FINISH: state_q <= S_IDLE;
        default:  state_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/psq_track.sv
module psq_track
  import psq_pkg::*;
#(
  parameter int POS_W       = 11,
  parameter bit DIRECT_MODE = 1'b0,
  parameter int INIT_PHASE  = 0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    step_ok_i,
  input  logic                    step_up_i,
  output logic signed [POS_W-1:0] pos_o
);

  localparam int LO    = pos_floor(DIRECT_MODE);
  localparam int HI    = pos_ceiling(DIRECT_MODE);
  localparam int START = DIRECT_MODE ? 0 : INIT_PHASE;

  // One step in the requested direction, held inside the mode's range.
  function automatic logic signed [POS_W-1:0] bounded_step(
    input logic signed [POS_W-1:0] cur, input logic up);
    int p;
    p = int'(cur) + (up ? 1 : -1);
    if (p > HI) p = HI;
    if (p < LO) p = LO;
    return POS_W'(p);
  endfunction

  logic signed [POS_W-1:0] pos_q;

  always_ff @(posedge clk) begin
    if (rst)            pos_q <= POS_W'(START);
    else if (step_ok_i) pos_q <= bounded_step(pos_q, step_up_i);
  end

  assign pos_o = pos_q;

endmodule

// File: rtl/phase_step_seq.sv
module phase_step_seq #(
  parameter int STEP_W      = 11,
  parameter int POS_W       = 11,
  parameter bit DIRECT_MODE = 1'b0,
  parameter int INIT_PHASE  = 0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     locked_i,
  input  logic                     req_valid_i,
  output logic                     req_ready_o,
  input  logic signed [STEP_W-1:0] req_steps_i,
  output logic                     ps_en_o,
  output logic                     ps_incdec_o,
  input  logic                     ps_done_i,
  input  logic                     ps_ovf_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic                     ovf_err_o,
  output logic signed [POS_W-1:0]  phase_pos_o
);

  logic [STEP_W-1:0] mag_w;
  logic              up_w;
  logic              zero_w;
  logic              accept_w;
  logic              step_ok_w;
  logic              step_ovf_w;

  psq_req_decode #(.STEP_W(STEP_W)) u_decode (
    .steps_i (req_steps_i),
    .mag_o   (mag_w),
    .up_o    (up_w),
    .zero_o  (zero_w)
  );

  psq_ctrl #(.STEP_W(STEP_W)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .locked_i    (locked_i),
    .req_valid_i (req_valid_i),
    .req_mag_i   (mag_w),
    .req_up_i    (up_w),
    .req_zero_i  (zero_w),
    .ps_done_i   (ps_done_i),
    .ps_ovf_i    (ps_ovf_i),
    .req_ready_o (req_ready_o),
    .accept_o    (accept_w),
    .ps_en_o     (ps_en_o),
    .ps_dir_o    (ps_incdec_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (ovf_err_o),
    .step_ok_o   (step_ok_w),
    .step_ovf_o  (step_ovf_w)
  );

  psq_track #(
    .POS_W       (POS_W),
    .DIRECT_MODE (DIRECT_MODE),
    .INIT_PHASE  (INIT_PHASE)
  ) u_track (
    .clk       (clk),
    .rst       (rst),
    .step_ok_i (step_ok_w),
    .step_up_i (ps_incdec_o),
    .pos_o     (phase_pos_o)
  );

endmodule

// File: rtl/phase_step_seq_chk.sv
module phase_step_seq_chk
  import psq_pkg::*;
#(
  parameter int STEP_W      = 11,
  parameter int POS_W       = 11,
  parameter bit DIRECT_MODE = 1'b0
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     locked_i,
  input logic                     req_ready_o,
  input logic signed [STEP_W-1:0] req_steps_i,
  input logic                     ps_en_o,
  input logic                     ps_done_i,
  input logic                     busy_o,
  input logic                     done_o,
  input logic                     ovf_err_o,
  input logic signed [POS_W-1:0]  phase_pos_o,
  input logic                     accept_w,
  input logic                     step_ovf_w
);

  localparam int LO = pos_floor(DIRECT_MODE);
  localparam int HI = pos_ceiling(DIRECT_MODE);

  // Set by a step command, cleared by its completion or by loss of lock.
  logic outstanding_q;
  always_ff @(posedge clk) begin
    if (rst || !locked_i) outstanding_q <= 1'b0;
    else if (ps_en_o)     outstanding_q <= 1'b1;
    else if (ps_done_i)   outstanding_q <= 1'b0;
  end

  p_en_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    ps_en_o |=> !ps_en_o);

  p_wait_done_r3: assert property (@(posedge clk) disable iff (rst)
    outstanding_q |-> !ps_en_o);

  p_in_range_r4: assert property (@(posedge clk) disable iff (rst)
    (int'(phase_pos_o) >= LO) && (int'(phase_pos_o) <= HI));

  p_ovf_hold_r5: assert property (@(posedge clk) disable iff (rst)
    step_ovf_w |=> $stable(phase_pos_o));

  p_ovf_flag_r5: assert property (@(posedge clk) disable iff (rst)
    step_ovf_w |=> (ovf_err_o && done_o && !ps_en_o));

  p_err_clear_r6: assert property (@(posedge clk) disable iff (rst)
    accept_w |=> !ovf_err_o);

  p_zero_done_r7: assert property (@(posedge clk) disable iff (rst)
    (accept_w && req_steps_i == '0) |=> (done_o && !ps_en_o));

  p_busy_not_ready_r8: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> !req_ready_o);

  p_lock_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !locked_i |=> (!busy_o && !ps_en_o));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done_o |=> (!done_o && !busy_o));

endmodule

bind phase_step_seq phase_step_seq_chk #(
  .STEP_W      (STEP_W),
  .POS_W       (POS_W),
  .DIRECT_MODE (DIRECT_MODE)
) i_chk (
  .clk         (clk),
  .rst         (rst),
  .locked_i    (locked_i),
  .req_ready_o (req_ready_o),
  .req_steps_i (req_steps_i),
  .ps_en_o     (ps_en_o),
  .ps_done_i   (ps_done_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .ovf_err_o   (ovf_err_o),
  .phase_pos_o (phase_pos_o),
  .accept_w    (accept_w),
  .step_ovf_w  (step_ovf_w)
);

// File: tb/test_phase_step_seq.sv
module test_phase_step_seq;

  localparam int INIT = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic locked = 1'b1;
  logic req_valid = 1'b0;
  logic signed [10:0] req_steps = '0;
  logic ps_done = 1'b0;
  logic ps_ovf = 1'b0;
  logic req_ready, ps_en, ps_incdec, busy, done, ovf_err;
  logic signed [10:0] pos;

  logic d_valid = 1'b0;
  logic signed [10:0] d_steps = '0;
  logic d_done = 1'b0;
  logic d_ovf = 1'b0;
  logic d_ready, d_en, d_dir, d_busy, d_fin, d_err;
  logic signed [10:0] d_pos;

  int checks = 0;
  int fails = 0;
  int model_pos = INIT;

  always #2 clk = ~clk;

  phase_step_seq #(.INIT_PHASE(INIT)) i_phase_step_seq (
    .clk(clk), .rst(rst), .locked_i(locked),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_steps_i(req_steps),
    .ps_en_o(ps_en), .ps_incdec_o(ps_incdec), .ps_done_i(ps_done), .ps_ovf_i(ps_ovf),
    .busy_o(busy), .done_o(done), .ovf_err_o(ovf_err), .phase_pos_o(pos)
  );

  phase_step_seq #(.DIRECT_MODE(1'b1), .INIT_PHASE(INIT)) i_direct (
    .clk(clk), .rst(rst), .locked_i(1'b1),
    .req_valid_i(d_valid), .req_ready_o(d_ready), .req_steps_i(d_steps),
    .ps_en_o(d_en), .ps_incdec_o(d_dir), .ps_done_i(d_done), .ps_ovf_i(d_ovf),
    .busy_o(d_busy), .done_o(d_fin), .ovf_err_o(d_err), .phase_pos_o(d_pos)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Clock manager model for variable mode: a step at the range end overflows.
  function automatic bit dev_overflow(input int cur, input bit up);
    return up ? (cur >= 255) : (cur <= -255);
  endfunction

  task automatic run_req(input int steps, input bit poke);
    int  n = (steps < 0) ? -steps : steps;
    bit  up = (steps > 0);
    int  good = 0;
    bit  ovf_seen = 1'b0;
    bit  ovf;
    int  dly;
    chk(req_ready == 1'b1, "R8 ready when idle", int'(req_ready), 1);
    req_valid = 1'b1;
    req_steps = 11'(steps);
    @(negedge clk);
    req_valid = 1'b0;
    if (n == 0) begin
      chk(done == 1'b1 && ps_en == 1'b0, "R7 zero request done", int'(done), 1);
      chk(ovf_err == 1'b0, "R6 error cleared", int'(ovf_err), 0);
      @(negedge clk);
      chk(busy == 1'b0 && ps_en == 1'b0, "R7 idle after zero", int'(busy), 0);
      return;
    end
    chk(ovf_err == 1'b0, "R6 error cleared on accept", int'(ovf_err), 0);
    while (!ovf_seen && good < n) begin
      chk(ps_en == 1'b1, "R3 enable issued", int'(ps_en), 1);
      chk(ps_incdec == up, "R2 direction", int'(ps_incdec), int'(up));
      chk(req_ready == 1'b0, "R8 not ready while busy", int'(req_ready), 0);
      dly = $urandom_range(0, 4);
      @(negedge clk);
      chk(ps_en == 1'b0, "R2 single-cycle enable", int'(ps_en), 0);
      for (int i = 0; i < dly; i++) begin
        if (poke && i == 0) begin
          req_valid = 1'b1;
          req_steps = 11'sd7;
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk(ps_en == 1'b0, "R3 no enable before completion", int'(ps_en), 0);
      end
      ovf = dev_overflow(model_pos, up);
      ps_done = 1'b1;
      ps_ovf = ovf;
      @(negedge clk);
      ps_done = 1'b0;
      ps_ovf = 1'b0;
      if (ovf) ovf_seen = 1'b1;
      else begin
        model_pos += up ? 1 : -1;
        good++;
      end
      chk(pos == model_pos, ovf ? "R5 position held" : "R4 position step",
          int'(pos), model_pos);
    end
    chk(done == 1'b1 && ps_en == 1'b0, "R10 done after last completion", int'(done), 1);
    chk(ovf_err == ovf_seen, "R5 error flag", int'(ovf_err), int'(ovf_seen));
    chk(good == (ovf_seen ? good : n), "R3 step count", good, n);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R10 single done, idle", int'(done), 0);
    chk(ovf_err == ovf_seen, "R5 sticky error", int'(ovf_err), int'(ovf_seen));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && ps_en == 1'b0, "R1 reset idle", int'(busy), 0);
    chk(pos == INIT, "R1 reset position variable", int'(pos), INIT);
    chk(ovf_err == 1'b0 && req_ready == 1'b1, "R1 reset flags", int'(ovf_err), 0);
    chk(d_pos == 0, "R1 direct mode starts at zero", int'(d_pos), 0);

    run_req(5, 1'b0);
    run_req(-3, 1'b1);
    run_req(0, 1'b0);
    run_req(300, 1'b0);
    chk(pos == 255, "R4 upper limit", int'(pos), 255);
    run_req(-2, 1'b1);
    run_req(-600, 1'b1);
    chk(pos == -255, "R4 lower limit", int'(pos), -255);
    run_req(-1, 1'b0);
    run_req(0, 1'b0);

    // R8: request ignored while lock is low
    locked = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b0, "R8 not ready without lock", int'(req_ready), 0);
    req_valid = 1'b1;
    req_steps = 11'sd9;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b0 && ps_en == 1'b0, "R8 request ignored", int'(busy), 0);
    @(negedge clk);
    chk(ps_en == 1'b0 && pos == model_pos, "R8 no step without lock", int'(pos), model_pos);
    locked = 1'b1;
    @(negedge clk);

    // R9: lock lost in the middle of a request
    req_valid = 1'b1;
    req_steps = 11'sd4;
    @(negedge clk);
    req_valid = 1'b0;
    chk(ps_en == 1'b1, "R9 first enable", int'(ps_en), 1);
    locked = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0 && ps_en == 1'b0, "R9 idle after lock loss", int'(busy), 0);
    repeat (3) begin
      @(negedge clk);
      chk(ps_en == 1'b0, "R9 no enable while unlocked", int'(ps_en), 0);
    end
    chk(pos == model_pos, "R9 position kept", int'(pos), model_pos);
    locked = 1'b1;
    @(negedge clk);

    for (int k = 0; k < 25; k++) begin
      int s = int'($urandom_range(0, 60)) - 30;
      run_req(s, 1'(($urandom_range(0, 1))));
    end

    // Direct mode: +1, then -2 where the second step hits the floor at 0
    d_valid = 1'b1;
    d_steps = 11'sd1;
    @(negedge clk);
    d_valid = 1'b0;
    chk(d_en == 1'b1 && d_dir == 1'b1, "R2 direct increment", int'(d_dir), 1);
    @(negedge clk);
    d_done = 1'b1;
    @(negedge clk);
    d_done = 1'b0;
    chk(d_pos == 1 && d_fin == 1'b1, "R4 direct step up", int'(d_pos), 1);
    @(negedge clk);
    d_valid = 1'b1;
    d_steps = -11'sd2;
    @(negedge clk);
    d_valid = 1'b0;
    chk(d_en == 1'b1 && d_dir == 1'b0, "R2 direct decrement", int'(d_dir), 0);
    @(negedge clk);
    d_done = 1'b1;
    @(negedge clk);
    d_done = 1'b0;
    chk(d_pos == 0 && d_en == 1'b1, "R4 direct step down", int'(d_pos), 0);
    @(negedge clk);
    d_done = 1'b1;
    d_ovf = 1'b1;
    @(negedge clk);
    d_done = 1'b0;
    d_ovf = 1'b0;
    chk(d_pos == 0, "R5 direct position held", int'(d_pos), 0);
    chk(d_err == 1'b1 && d_fin == 1'b1, "R5 direct overflow flagged", int'(d_err), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule